// File: doc/BRIEF.md
# Switch Watchdog Interrupt Register Block

This block holds the status and control state of a hardware watchdog inside a network switch. Three internal monitors report errors with one-cycle pulses: the egress path, the queue controller and cut-through forwarding. Each pulse latches an event bit and a sticky history bit. When an event bit is present and its enable is set, the block drives an active-low, level-signalled interrupt line. That line feeds input 15 of the switch's 16-input global interrupt collector. Software can also set a force flag to raise a test interrupt when no real error is present.

All software access goes through one 16-bit indirect register. Bit 15 is a commit flag. Bits 14:8 hold a sub-register index and bits 7:0 hold data. The block never recovers by itself. Software reads the cause, clears the events and rewrites the enables after it has reset the switch. A synchronous switch software reset input clears the watchdog's event, history and enable state but leaves the index pointer unchanged.

Top module: `wdog_irq_regs`

## Requirements
- R1: After `rst_n` is released, all event, history and enable bits are 0, `irq_n` is 1 and `reg_rdata` reads 0x0000.
- R2: Every write loads the index pointer from bits 14:8. A write with bit 15 clear changes nothing else. `reg_rdata` always shows 0 in bit 15, the pointer in bits 14:8 and the selected sub-register in bits 7:0.
- R3: A committed write (bit 15 set) to index 0x11 stores bits 3:0 into the enable register. Bit 3 enables cut-through, bit 2 the queue controller, bit 1 egress and bit 0 the force flag. Bits 7:4 read as 0. No other write changes the enables.
- R4: A pulse on `err_cut`, `err_qc` or `err_egress` sets event bit 3, 2 or 1 (index 0x12) at the next clock edge. That bit stays set until software clears it; nothing clears it automatically.
- R5: In a committed write to index 0x12, a 1 in bits 3:1 clears that event bit. Bit 0 is written as the force flag value. An error pulse in the same cycle as a clear leaves the bit set.
- R6: History bits (index 0x13) are set alongside each event bit, including the force flag. Clearing events does not clear them. A committed write to 0x13 clears the history bits written as 1.
- R7: Index 0x10 reads status, which is the event bits ANDed with the enable bits.
- R8: `irq_n` is 0 while any status bit is set and 1 otherwise. It follows the same clock edge that updates the event or enable bits.
- R9: Setting the force flag while enable bit 0 is set drives `irq_n` low with no error pulse.
- R10: Index 0x00 reads the source code. Bit 7 is set when any status bit is set. Bits 1:0 give the highest set status bit, with bit 3 at the top of the priority. The code is 0x00 when status is empty.
- R11: Indexes other than 0x00, 0x10–0x13 read 0x00 in bits 7:0. Committed writes to 0x00, 0x10 or an unimplemented index change no state.
- R12: A one-cycle `sw_rst` clears event, history and enable at the next edge, which returns `irq_n` to 1. The pointer is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous switch software reset pulse |
| err_egress | input | 1 | Egress monitor error pulse |
| err_qc | input | 1 | Queue controller error pulse |
| err_cut | input | 1 | Cut-through monitor error pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Commit flag, index, data |
| reg_rdata | output | 16 | Pointer and selected sub-register |
| irq_n | output | 1 | Active-low watchdog interrupt |

## Verification
Each error pulse, write or `sw_rst` is captured at the first rising edge after it is driven. The bench drives all stimulus on falling edges. After the capturing rising edge, `irq_n` and `reg_rdata` are combinational views of the flops, so every result is due half a cycle after that edge. The bench samples it at the next falling edge. A read is a pointer-only write followed by a sample at the next falling edge, so every read costs exactly one cycle and no check waits on a variable delay.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned PTR_W = 7;
  localparam int unsigned DAT_W = 8;
  localparam int unsigned NSRC  = 4;
  localparam int unsigned IXW   = $clog2(NSRC);

  localparam logic [PTR_W-1:0] IX_SRC  = 7'h00;
  localparam logic [PTR_W-1:0] IX_STAT = 7'h10;
  localparam logic [PTR_W-1:0] IX_EN   = 7'h11;
  localparam logic [PTR_W-1:0] IX_EVT  = 7'h12;
  localparam logic [PTR_W-1:0] IX_HIST = 7'h13;

  typedef enum logic [2:0] {
    SEL_SRC, SEL_STAT, SEL_EN, SEL_EVT, SEL_HIST, SEL_NONE
  } sel_e;

  function automatic sel_e decode_idx(input logic [PTR_W-1:0] ix);
    sel_e s;
    case (ix)
      IX_SRC:  s = SEL_SRC;
      IX_STAT: s = SEL_STAT;
      IX_EN:   s = SEL_EN;
      IX_EVT:  s = SEL_EVT;
      IX_HIST: s = SEL_HIST;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

  // Highest set status bit wins; bit 7 flags a pending interrupt.
  function automatic logic [DAT_W-1:0] src_code(input logic [NSRC-1:0] st);
    logic [DAT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (st[i]) c[IXW-1:0] = i[IXW-1:0];
    end
    c[DAT_W-1] = |st;
    return c;
  endfunction

  function automatic logic [DAT_W-1:0] widen(input logic [NSRC-1:0] v);
    return {{(DAT_W-NSRC){1'b0}}, v};
  endfunction
endpackage

// File: rtl/wdog_access_port.sv
module wdog_access_port
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [15:0]      reg_wdata,
  output logic [PTR_W-1:0] ptr_q,
  output logic [DAT_W-1:0] wval,
  output logic             en_we,
  output logic             evt_we,
  output logic             hist_we
);
  logic commit;
  sel_e wsel;

  assign commit = reg_wr & reg_wdata[15];
  assign wsel   = decode_idx(reg_wdata[8+PTR_W-1:8]);
  assign wval   = reg_wdata[DAT_W-1:0];

  assign en_we   = commit && (wsel == SEL_EN);
  assign evt_we  = commit && (wsel == SEL_EVT);
  assign hist_we = commit && (wsel == SEL_HIST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (reg_wr) ptr_q <= reg_wdata[8+PTR_W-1:8];
  end
endmodule

// File: rtl/wdog_flag_cell.sv
module wdog_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (clr_all) q <= 1'b0;
    else if (set_i)   q <= 1'b1;
    else if (clr_i)   q <= 1'b0;
  end
endmodule

// File: rtl/wdog_flag_bank.sv
module wdog_flag_bank
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_rst,
  input  logic [NSRC-1:0] err_vec,
  input  logic [NSRC-1:0] wbits,
  input  logic            en_we,
  input  logic            evt_we,
  input  logic            hist_we,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] evt_q,
  output logic [NSRC-1:0] hist_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (sw_rst) en_q <= '0;
    else if (en_we)  en_q <= wbits;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic ev_set, ev_clr;
    if (i == 0) begin : g_force
      assign ev_set = evt_we & wbits[0];
      assign ev_clr = evt_we & ~wbits[0];
    end else begin : g_err
      assign ev_set = err_vec[i];
      assign ev_clr = evt_we & wbits[i];
    end

    wdog_flag_cell u_evt (
      .clk(clk), .rst_n(rst_n), .clr_all(sw_rst),
      .set_i(ev_set), .clr_i(ev_clr), .q(evt_q[i])
    );

    wdog_flag_cell u_hist (
      .clk(clk), .rst_n(rst_n), .clr_all(sw_rst),
      .set_i(ev_set), .clr_i(hist_we & wbits[i]), .q(hist_q[i])
    );
  end
endmodule

// File: rtl/wdog_read_mux.sv
module wdog_read_mux
  import wdog_pkg::*;
(
  input  logic [PTR_W-1:0] ptr_q,
  input  logic [NSRC-1:0]  status,
  input  logic [NSRC-1:0]  en_q,
  input  logic [NSRC-1:0]  evt_q,
  input  logic [NSRC-1:0]  hist_q,
  output logic [15:0]      reg_rdata
);
  logic [DAT_W-1:0] dat;

  always_comb begin
    case (decode_idx(ptr_q))
      SEL_SRC:  dat = src_code(status);
      SEL_STAT: dat = widen(status);
      SEL_EN:   dat = widen(en_q);
      SEL_EVT:  dat = widen(evt_q);
      SEL_HIST: dat = widen(hist_q);
      default:  dat = '0;
    endcase
  end

  assign reg_rdata = {1'b0, ptr_q, dat};
endmodule

// File: rtl/wdog_irq_regs.sv
module wdog_irq_regs
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_rst,
  input  logic        err_egress,
  input  logic        err_qc,
  input  logic        err_cut,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq_n
);
  logic [PTR_W-1:0] ptr_q;
  logic [DAT_W-1:0] wval;
  logic             en_we, evt_we, hist_we;
  logic [NSRC-1:0]  err_vec, en_q, evt_q, hist_q, status;

  assign err_vec = {err_cut, err_qc, err_egress, 1'b0};

  wdog_access_port u_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ptr_q(ptr_q), .wval(wval), .en_we(en_we), .evt_we(evt_we),
    .hist_we(hist_we)
  );

  wdog_flag_bank u_bank (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .err_vec(err_vec),
    .wbits(wval[NSRC-1:0]), .en_we(en_we), .evt_we(evt_we),
    .hist_we(hist_we), .en_q(en_q), .evt_q(evt_q), .hist_q(hist_q)
  );

  assign status = evt_q & en_q;
  assign irq_n  = ~(|status);

  wdog_read_mux u_rd (
    .ptr_q(ptr_q), .status(status), .en_q(en_q), .evt_q(evt_q),
    .hist_q(hist_q), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/wdog_irq_chk.sv
module wdog_irq_chk
  import wdog_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sw_rst,
  input logic            reg_wr,
  input logic [15:0]     reg_wdata,
  input logic [NSRC-1:0] err_vec,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] evt_q,
  input logic [NSRC-1:0] hist_q,
  input logic            irq_n
);
  logic commit, en_hit, evt_hit, hist_hit;
  assign commit   = reg_wr & reg_wdata[15];
  assign en_hit   = commit && (reg_wdata[14:8] == IX_EN);
  assign evt_hit  = commit && (reg_wdata[14:8] == IX_EVT);
  assign hist_hit = commit && (reg_wdata[14:8] == IX_HIST);

  // R3 / R11: only a committed enable write or sw_rst moves the enables
  assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_hit && !sw_rst) |=> $stable(en_q));

  // R4: a pulse is captured at the next edge
  assert_evt_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && err_vec != '0) |=> ((evt_q & $past(err_vec)) == $past(err_vec)));

  // R4: error event bits never fall without a clear
  assert_evt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && !evt_hit) |=>
      ((evt_q[NSRC-1:1] & $past(evt_q[NSRC-1:1])) == $past(evt_q[NSRC-1:1])));

  // R6: history bits never fall without a history write
  assert_hist_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst && !hist_hit) |=> ((hist_q & $past(hist_q)) == $past(hist_q)));

  // R8: interrupt line tracks enabled events
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ((evt_q & en_q) == '0));

  // R12: software reset clears the watchdog state
  assert_swrst_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (evt_q == '0 && en_q == '0 && hist_q == '0 && irq_n));
endmodule

bind wdog_irq_regs wdog_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .err_vec(err_vec), .en_q(en_q), .evt_q(evt_q),
  .hist_q(hist_q), .irq_n(irq_n)
);

// File: tb/sim_wdog_irq_regs.sv
`timescale 1ns/1ps
module sim_wdog_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_rst = 1'b0;
  logic        err_egress = 1'b0, err_qc = 1'b0, err_cut = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_n;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_irq_regs u0 (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .err_egress(err_egress),
    .err_qc(err_qc), .err_cut(err_cut), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  localparam logic [6:0] P_SRC = 7'h00, P_STAT = 7'h10, P_EN = 7'h11,
                         P_EVT = 7'h12, P_HIST = 7'h13;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  // drive on falling edge, commit at rising edge, return at next falling edge
  task automatic wr(input logic [15:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic put(input logic [6:0] ix, input logic [7:0] d);
    wr({1'b1, ix, d});
  endtask

  task automatic rd(input string req, input logic [6:0] ix, input logic [7:0] exp);
    wr({1'b0, ix, 8'h00});
    chk(req, reg_rdata, {1'b0, ix, exp});
  endtask

  // bits: {cut, qc, egress}
  task automatic pulse(input logic [2:0] m);
    {err_cut, err_qc, err_egress} = m;
    @(negedge clk);
    {err_cut, err_qc, err_egress} = 3'b000;
  endtask

  task automatic t_reset;
    chk("R1 irq_n", {15'd0, irq_n}, 16'h0001);
    chk("R1 rdata", reg_rdata, 16'h0000);
    rd("R1 enable", P_EN, 8'h00);
    rd("R1 event", P_EVT, 8'h00);
    rd("R1 history", P_HIST, 8'h00);
  endtask

  task automatic t_pointer;
    wr(16'h1180);                 // pointer only, data ignored
    chk("R2 ptr read", reg_rdata, 16'h1100);
    put(P_EN, 8'hFF);
    rd("R3 enable upper zero", P_EN, 8'h0F);
  endtask

  task automatic t_egress;
    pulse(3'b001);
    chk("R8 irq low", {15'd0, irq_n}, 16'h0000);
    rd("R4 event egress", P_EVT, 8'h02);
    rd("R7 status", P_STAT, 8'h02);
    rd("R6 history", P_HIST, 8'h02);
    rd("R10 source egress", P_SRC, 8'h81);
    repeat (10) @(negedge clk);
    rd("R4 no auto recovery", P_EVT, 8'h02);
    chk("R4 irq held", {15'd0, irq_n}, 16'h0000);
    put(P_EVT, 8'h02);
    chk("R8 irq released", {15'd0, irq_n}, 16'h0001);
    rd("R5 cleared", P_EVT, 8'h00);
    rd("R6 history kept", P_HIST, 8'h02);
  endtask

  task automatic t_mask;
    put(P_EN, 8'h04);
    pulse(3'b100);
    rd("R4 event cut", P_EVT, 8'h08);
    rd("R7 masked status", P_STAT, 8'h00);
    chk("R8 masked irq", {15'd0, irq_n}, 16'h0001);
    rd("R10 source empty", P_SRC, 8'h00);
    pulse(3'b010);
    chk("R8 qc irq", {15'd0, irq_n}, 16'h0000);
    rd("R10 source qc", P_SRC, 8'h82);
    put(P_EN, 8'h0C);
    rd("R10 priority cut", P_SRC, 8'h83);
    put(P_EVT, 8'h0E);
    chk("R5 clear all", {15'd0, irq_n}, 16'h0001);
    rd("R5 event empty", P_EVT, 8'h00);
    rd("R6 history all", P_HIST, 8'h0E);
    put(P_HIST, 8'h08);
    rd("R6 history w1c", P_HIST, 8'h06);
  endtask

  task automatic t_force;
    put(P_EN, 8'h01);
    put(P_EVT, 8'h01);
    chk("R9 force irq", {15'd0, irq_n}, 16'h0000);
    rd("R10 source force", P_SRC, 8'h80);
    rd("R6 history force", P_HIST, 8'h07);
    put(P_EVT, 8'h00);
    chk("R9 force off", {15'd0, irq_n}, 16'h0001);
  endtask

  task automatic t_collide;
    put(P_EN, 8'h02);
    err_egress = 1'b1;
    wr({1'b1, P_EVT, 8'h02});     // clear and pulse in the same cycle
    err_egress = 1'b0;
    rd("R5 set wins", P_EVT, 8'h02);
    put(P_EVT, 8'h02);
    rd("R5 then cleared", P_EVT, 8'h00);
  endtask

  task automatic t_unimpl;
    put(P_EN, 8'h01);
    rd("R11 unimpl read", 7'h05, 8'h00);
    put(P_STAT, 8'hFF);
    put(P_SRC, 8'hFF);
    put(7'h05, 8'hFF);
    rd("R11 enable untouched", P_EN, 8'h01);
    rd("R11 event untouched", P_EVT, 8'h00);
  endtask

  task automatic t_swrst;
    put(P_EN, 8'h0F);
    pulse(3'b010);
    chk("R12 irq before", {15'd0, irq_n}, 16'h0000);
    wr(16'h1300);                 // park pointer on history
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    chk("R12 irq after", {15'd0, irq_n}, 16'h0001);
    chk("R12 pointer kept", reg_rdata, 16'h1300);
    rd("R12 enable", P_EN, 8'h00);
    rd("R12 event", P_EVT, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pointer;
    t_egress;
    t_mask;
    t_force;
    t_collide;
    t_unimpl;
    t_swrst;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule